// File: doc/BRIEF.md
# Touch Sample FIFO

This block is a four-entry queue that sits between a touch measurement sequencer and the processor bus. The sequencer offers one sample at a time as a 10-bit X coordinate, a 10-bit Y coordinate and a pen-level flag. The block keeps each sample as one entry and hands the samples to software in arrival order through a small register window with single-cycle reads and writes.

Software reads a status word to learn whether the queue is empty and whether a sample was lost. Each read of the data word returns the oldest entry packed into one 32-bit word and removes that entry. A level-sensitive interrupt tells software when enough samples are waiting. A control bit selects how many: a single sample, or a full set of four. Reading the data word until the empty bit sets drains the queue and clears the loss flag.

Register word addresses: 0 is status, 1 is data, 2 is control, and 3 is unused. Read data is registered and appears on `bus_rdata` in the cycle after the read.

Top module: `touch_sample_fifo`

## Requirements
- R1: After reset the status word reads 0x00000080 (empty set, overrun clear), `irq` is low and `bus_rdata` is zero.
- R2: A data read returns the pen flag in bit 31, X in bits 25:16 and Y in bits 9:0, and every other bit reads zero.
- R3: Data reads return the samples in the order they were pushed, and each data read of a non-empty queue removes exactly one entry.
- R4: Status bit 7 reads 1 exactly when the queue holds no entry at the time of the status read.
- R5: A push while four entries are held and no data read happens in the same cycle is dropped, leaves the stored entries unchanged and sets status bit 8.
- R6: Status bit 8 stays set until a data read removes the last entry, and then clears.
- R7: A data read while the queue is empty returns the last data word read before it and leaves the queue unchanged.
- R8: With control bit 0 set to 1, `irq` is high exactly while four entries are held.
- R9: With control bit 0 cleared to 0, `irq` is high exactly while at least one entry is held.
- R10: A push and a data read in the same cycle on a full queue both take effect: the oldest entry is returned, the new sample is stored and no overrun is flagged.
- R11: Control reads back bit 0 as written with all other bits zero, and a read of word address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_push | input | 1 | Sequencer offers a sample this cycle |
| smp_x | input | 10 | X coordinate of the offered sample |
| smp_y | input | 10 | Y coordinate of the offered sample |
| smp_pen | input | 1 | Pen-level flag of the offered sample |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on fill threshold |

## Verification
The checker watches the fill level and the loss flag every cycle: a dropped push into a full queue must raise the flag, the flag must hold until the last entry leaves, a push and pop on a full queue must swap cleanly, an empty data read must leave the fill alone, the status empty bit must match the fill at read time, and the interrupt must stay low below its threshold in either mode. What those properties cannot see is the content: the packing of each field into the word, the ordering of entries, the fact that a dropped sample really never appears, and the replay of the previous word on an empty read, so the bench's scenarios compare every returned word against values built from the pushed samples.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   localparam int REG_ADDR_W = 2;
   localparam int BUS_W      = 32;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_STATUS = 2'd0,
      REG_DATA   = 2'd1,
      REG_CTRL   = 2'd2,
      REG_SPARE  = 2'd3
   } tsf_reg_e;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 21,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_req,
   input  logic [ENTRY_W-1:0] wr_entry,
   input  logic               rd_req,
   output logic [ENTRY_W-1:0] head_entry,
   output logic [CNT_W-1:0]   fill,
   output logic               ovr
);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]   fill_q;
   logic               ovr_q;
   logic               rd_ok, wr_ok;

   assign rd_ok = rd_req && (fill_q != '0);
   assign wr_ok = wr_req && ((fill_q != FULL_C) || rd_ok);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_ok && (wr_ptr_q == PTR_W'(i))) slot_q[i] <= wr_entry;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
         ovr_q    <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         if (rd_ok) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         fill_q <= fill_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
         if (wr_req && !wr_ok)
            ovr_q <= 1'b1;
         else if (rd_ok && !wr_ok && (fill_q == ONE_C))
            ovr_q <= 1'b0;
      end
   end

   assign head_entry = slot_q[rd_ptr_q];
   assign fill       = fill_q;
   assign ovr        = ovr_q;
endmodule

// File: rtl/tsf_irq.sv
module tsf_irq #(
   parameter int DEPTH  = 4,
   parameter int THRESH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] fill,
   input  logic             thr_en,
   output logic             irq
);
   localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH);

   if (THRESH <= 1) begin : g_single
      // threshold equals the default level, the option bit changes nothing
      logic unused_thr;
      assign unused_thr = thr_en;
      assign irq = (fill != '0);
   end else begin : g_multi
      always_comb begin
         if (thr_en) irq = (fill >= THR_C);
         else        irq = (fill != '0);
      end
   end
endmodule

// File: rtl/tsf_regif.sv
module tsf_regif
   import tsf_pkg::*;
#(
   parameter int COORD_W   = 10,
   parameter int X_LSB     = 16,
   parameter int PEN_BIT   = 31,
   parameter int EMPTY_BIT = 7,
   parameter int OVR_BIT   = 8,
   parameter int CNT_W     = 3,
   localparam int ENTRY_W  = 2 * COORD_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   input  logic [ENTRY_W-1:0]    head_entry,
   input  logic [CNT_W-1:0]      fill,
   input  logic                  ovr,
   output logic                  pop_req,
   output logic                  thr_en,
   output logic [BUS_W-1:0]      bus_rdata
);
   logic [BUS_W-1:0] rdata_q, last_q, head_word, stat_word, ctrl_word;
   logic             thr_q, rd_cyc, wr_cyc, empty;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata[BUS_W-1:1];
   assign rd_cyc  = bus_en && !bus_we;
   assign wr_cyc  = bus_en && bus_we;
   assign empty   = (fill == '0);
   assign pop_req = rd_cyc && (bus_addr == REG_DATA);

   // entry layout is {pen, x, y}
   always_comb begin
      head_word = '0;
      head_word[PEN_BIT]              = head_entry[ENTRY_W-1];
      head_word[X_LSB +: COORD_W]     = head_entry[2*COORD_W-1:COORD_W];
      head_word[COORD_W-1:0]          = head_entry[COORD_W-1:0];
      stat_word = '0;
      stat_word[EMPTY_BIT]            = empty;
      stat_word[OVR_BIT]              = ovr;
      ctrl_word = '0;
      ctrl_word[0]                    = thr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         last_q  <= '0;
         thr_q   <= 1'b0;
      end else begin
         if (wr_cyc && (bus_addr == REG_CTRL)) thr_q <= bus_wdata[0];
         if (rd_cyc) begin
            unique case (bus_addr)
               REG_STATUS: rdata_q <= stat_word;
               REG_CTRL:   rdata_q <= ctrl_word;
               REG_DATA: begin
                  if (empty) begin
                     rdata_q <= last_q;
                  end else begin
                     rdata_q <= head_word;
                     last_q  <= head_word;
                  end
               end
               default:    rdata_q <= '0;
            endcase
         end
      end
   end

   assign thr_en    = thr_q;
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/touch_sample_fifo.sv
module touch_sample_fifo
   import tsf_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int THRESH    = 4,
   parameter int COORD_W   = 10,
   parameter int X_LSB     = 16,
   parameter int PEN_BIT   = 31,
   parameter int EMPTY_BIT = 7,
   parameter int OVR_BIT   = 8,
   localparam int ENTRY_W  = 2 * COORD_W + 1,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_push,
   input  logic [COORD_W-1:0]    smp_x,
   input  logic [COORD_W-1:0]    smp_y,
   input  logic                  smp_pen,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   output logic                  irq
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (THRESH < 1 || THRESH > DEPTH) begin : g_bad_thresh
      $error("THRESH must lie between 1 and DEPTH");
   end
   if (COORD_W > X_LSB || X_LSB + COORD_W > PEN_BIT || PEN_BIT >= BUS_W) begin : g_bad_layout
      $error("data word fields overlap or exceed the bus width");
   end
   if (EMPTY_BIT == OVR_BIT || EMPTY_BIT >= BUS_W || OVR_BIT >= BUS_W) begin : g_bad_status
      $error("status bit positions invalid");
   end

   logic [ENTRY_W-1:0] head_w;
   logic [CNT_W-1:0]   fill_w;
   logic               ovr_w, pop_w, thr_en_w;

   tsf_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (smp_push),
      .wr_entry   ({smp_pen, smp_x, smp_y}),
      .rd_req     (pop_w),
      .head_entry (head_w),
      .fill       (fill_w),
      .ovr        (ovr_w)
   );

   tsf_regif #(
      .COORD_W(COORD_W), .X_LSB(X_LSB), .PEN_BIT(PEN_BIT),
      .EMPTY_BIT(EMPTY_BIT), .OVR_BIT(OVR_BIT), .CNT_W(CNT_W)
   ) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .head_entry (head_w),
      .fill       (fill_w),
      .ovr        (ovr_w),
      .pop_req    (pop_w),
      .thr_en     (thr_en_w),
      .bus_rdata  (bus_rdata)
   );

   tsf_irq #(.DEPTH(DEPTH), .THRESH(THRESH)) u_irq (
      .fill   (fill_w),
      .thr_en (thr_en_w),
      .irq    (irq)
   );
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker
   import tsf_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int THRESH    = 4,
   parameter int EMPTY_BIT = 7,
   parameter int CNT_W     = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  smp_push,
   input logic                  bus_en,
   input logic                  bus_we,
   input logic [REG_ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]      bus_rdata,
   input logic                  irq,
   input logic [CNT_W-1:0]      fill,
   input logic                  ovr,
   input logic                  thr_en
);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] THR_C  = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic data_rd, stat_rd;
   assign data_rd = bus_en && !bus_we && (bus_addr == REG_DATA);
   assign stat_rd = bus_en && !bus_we && (bus_addr == REG_STATUS);

   // R5
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_push && (fill == FULL_C) && !data_rd |=> ovr && (fill == FULL_C));

   // R6
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !(data_rd && (fill == ONE_C)) |=> ovr);

   // R10
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_push && data_rd && (fill == FULL_C) && !ovr |=> !ovr && (fill == FULL_C));

   // R4
   empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> bus_rdata[EMPTY_BIT] == ($past(fill) == '0));

   // R7
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && (fill == '0) |=> fill == CNT_W'($past(smp_push)));

   // R9
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0) |-> !irq);

   // R8
   irq_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_en && (fill < THR_C) |-> !irq);

   // R3
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_C);
endmodule

bind touch_sample_fifo tsf_checker #(
   .DEPTH(DEPTH), .THRESH(THRESH), .EMPTY_BIT(EMPTY_BIT), .CNT_W(CNT_W)
) u_tsf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_push  (smp_push),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .fill      (fill_w),
   .ovr       (ovr_w),
   .thr_en    (thr_en_w)
);

// File: tb/test_touch_sample_fifo.sv
module test_touch_sample_fifo;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_STAT = 2'd0, A_DATA = 2'd1, A_CTRL = 2'd2, A_SPARE = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        smp_push;
   logic [9:0]  smp_x, smp_y;
   logic        smp_pen;
   logic        bus_en, bus_we;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   touch_sample_fifo i_touch_sample_fifo (
      .clk(clk), .rst_n(rst_n), .smp_push(smp_push), .smp_x(smp_x), .smp_y(smp_y),
      .smp_pen(smp_pen), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] word_of(input logic [9:0] x, input logic [9:0] y, input logic pen);
      return {pen, 5'b0, x, 6'b0, y};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [9:0] x, input logic [9:0] y, input logic pen);
      @(negedge clk);
      smp_push = 1'b1; smp_x = x; smp_y = y; smp_pen = pen;
      @(negedge clk);
      smp_push = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      bus_read(A_STAT, d);
      chk("R1 status after reset", d, 32'h0000_0080);
   endtask

   task automatic t_format_order;
      logic [31:0] d;
      push(10'h3FF, 10'h000, 1'b1);
      push(10'h155, 10'h2AA, 1'b0);
      push(10'h000, 10'h3FF, 1'b1);
      bus_read(A_STAT, d);
      chk("R4 status not empty", d, 32'h0);
      bus_read(A_DATA, d);
      chk("R2 R3 first word", d, word_of(10'h3FF, 10'h000, 1'b1));
      bus_read(A_DATA, d);
      chk("R2 R3 second word", d, word_of(10'h155, 10'h2AA, 1'b0));
      bus_read(A_DATA, d);
      chk("R2 R3 third word", d, word_of(10'h000, 10'h3FF, 1'b1));
      bus_read(A_STAT, d);
      chk("R4 status empty after drain", d, 32'h0000_0080);
   endtask

   task automatic t_overrun;
      logic [31:0] d;
      push(10'h001, 10'h011, 1'b0);
      push(10'h002, 10'h022, 1'b1);
      push(10'h003, 10'h033, 1'b0);
      push(10'h004, 10'h044, 1'b1);
      push(10'h005, 10'h055, 1'b1);
      bus_read(A_STAT, d);
      chk("R5 overrun set on full push", d, 32'h0000_0100);
      bus_read(A_DATA, d);
      chk("R5 oldest kept", d, word_of(10'h001, 10'h011, 1'b0));
      bus_read(A_STAT, d);
      chk("R6 overrun sticky while not empty", d, 32'h0000_0100);
      bus_read(A_DATA, d);
      chk("R3 second", d, word_of(10'h002, 10'h022, 1'b1));
      bus_read(A_DATA, d);
      chk("R3 third", d, word_of(10'h003, 10'h033, 1'b0));
      bus_read(A_DATA, d);
      chk("R5 fourth kept", d, word_of(10'h004, 10'h044, 1'b1));
      bus_read(A_STAT, d);
      chk("R6 overrun cleared on flush", d, 32'h0000_0080);
      bus_read(A_DATA, d);
      chk("R5 dropped sample absent", d, word_of(10'h004, 10'h044, 1'b1));
   endtask

   task automatic t_empty_read;
      logic [31:0] d;
      bus_read(A_DATA, d);
      chk("R7 empty read repeats last word", d, word_of(10'h004, 10'h044, 1'b1));
      bus_read(A_STAT, d);
      chk("R7 still empty", d, 32'h0000_0080);
      push(10'h1A5, 10'h05A, 1'b0);
      bus_read(A_DATA, d);
      chk("R7 pointers unchanged", d, word_of(10'h1A5, 10'h05A, 1'b0));
   endtask

   task automatic t_irq;
      logic [31:0] d;
      bus_write(A_CTRL, 32'h1);
      push(10'h010, 10'h020, 1'b0);
      chk("R8 irq low at 1", {31'b0, irq}, 32'h0);
      push(10'h011, 10'h021, 1'b0);
      push(10'h012, 10'h022, 1'b0);
      chk("R8 irq low at 3", {31'b0, irq}, 32'h0);
      push(10'h013, 10'h023, 1'b0);
      chk("R8 irq high at 4", {31'b0, irq}, 32'h1);
      bus_read(A_DATA, d);
      chk("R8 irq drops at 3", {31'b0, irq}, 32'h0);
      bus_write(A_CTRL, 32'h0);
      chk("R9 irq high at 3 default mode", {31'b0, irq}, 32'h1);
      bus_read(A_DATA, d);
      bus_read(A_DATA, d);
      chk("R9 irq high at 1", {31'b0, irq}, 32'h1);
      bus_read(A_DATA, d);
      chk("R9 irq low when empty", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_push_pop_full;
      logic [31:0] d;
      push(10'h101, 10'h201, 1'b1);
      push(10'h102, 10'h202, 1'b0);
      push(10'h103, 10'h203, 1'b1);
      push(10'h104, 10'h204, 1'b0);
      @(negedge clk);
      smp_push = 1'b1; smp_x = 10'h105; smp_y = 10'h205; smp_pen = 1'b1;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = A_DATA;
      @(negedge clk);
      smp_push = 1'b0; bus_en = 1'b0;
      chk("R10 oldest returned", bus_rdata, word_of(10'h101, 10'h201, 1'b1));
      bus_read(A_STAT, d);
      chk("R10 no overrun", d, 32'h0);
      bus_read(A_DATA, d);
      chk("R10 order 2", d, word_of(10'h102, 10'h202, 1'b0));
      bus_read(A_DATA, d);
      chk("R10 order 3", d, word_of(10'h103, 10'h203, 1'b1));
      bus_read(A_DATA, d);
      chk("R10 order 4", d, word_of(10'h104, 10'h204, 1'b0));
      bus_read(A_DATA, d);
      chk("R10 new sample stored", d, word_of(10'h105, 10'h205, 1'b1));
      bus_read(A_STAT, d);
      chk("R10 empty at end", d, 32'h0000_0080);
   endtask

   task automatic t_ctrl;
      logic [31:0] d;
      bus_write(A_CTRL, 32'hFFFF_FFFF);
      bus_read(A_CTRL, d);
      chk("R11 control set", d, 32'h1);
      bus_write(A_CTRL, 32'hFFFF_FFFE);
      bus_read(A_CTRL, d);
      chk("R11 control clear", d, 32'h0);
      bus_read(A_SPARE, d);
      chk("R11 spare reads zero", d, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; smp_push = 1'b0; smp_x = '0; smp_y = '0; smp_pen = 1'b0;
      bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_format_order();
      t_overrun();
      t_empty_read();
      t_irq();
      t_push_pop_full();
      t_ctrl();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule